// File: doc/BRIEF.md
# Class-Aware Replacement State for One Cache Set

This block keeps the replacement state for a single set of a set-associative cache, 16 ways by default. Each way holds a valid bit, a recency rank and a 2-bit locality class. The class comes from the warp whose request filled the line. The ranks of all ways always form a permutation of 0 to WAYS-1. Rank 0 is the least recent and WAYS-1 the most recent.

A lookup hit names a way, and that way is promoted to the most recent rank. A fill names a way and a class. The line becomes valid, takes the class, and enters the recency order at a depth that depends on the class. Lines from cache-friendly warps enter at the top, lines from balanced warps in the middle, and lines from cache-hostile warps at the bottom. Every other way keeps its relative order.

The block drives the victim way continuously from its registered state. The surrounding cache reads the victim before it issues a fill. An invalid way is always offered first. Among valid ways, lines with a lower class priority are offered before lines with a higher one, and ties are broken by oldest rank. Tag storage, data storage and the computation of the class are outside the block.

Top module: `lc_repl_set`

## Requirements
- R1: After reset every way is invalid, way w holds rank w, and the victim output is way 0.
- R2: While any way is invalid, the victim is an invalid way, namely the invalid way with the lowest rank.
- R3: When all ways are valid, the victim belongs to the lowest class priority present. Class code 2'b00 (poor locality) has priority 0, 2'b01 (balanced) has priority 1, and 2'b10 or 2'b11 (good locality) have priority 2.
- R4: Among candidate ways of equal validity and priority, the victim is the one with the lowest rank. The ranks of all ways always stay a permutation of 0 to WAYS-1.
- R5: A hit on way w gives w rank WAYS-1 and lowers by one every rank above w's old rank. The class and valid bit of w are left unchanged.
- R6: A fill with a good-locality class (2'b10 or 2'b11) places the way at rank WAYS-1 and marks it valid with that class.
- R7: A fill with the balanced class (2'b01) places the way at rank WAYS/2.
- R8: A fill with the poor-locality class (2'b00) places the way at rank 0.
- R9: A fill that moves a way from rank r to a position p shifts only the ranks between r and p by one step toward r. All other ways keep their ranks.
- R10: When a hit and a fill are requested in the same cycle, only the fill takes effect.
- R11: A request takes effect at the clock edge that samples it. With no request, the state and the victim output are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 1 | Promote way_i to most recent |
| fill_i | input | 1 | Install a line in way_i with class cls_i |
| way_i | input | $clog2(WAYS) | Way addressed by the request |
| cls_i | input | 2 | Locality class of the filling warp |
| victim_o | output | $clog2(WAYS) | Way to be replaced next |

## Verification
The bench builds the block with WAYS = 4, so the middle insertion rank is 2 and the whole rank state has only 24 orderings. At that size a few thousand pseudo-random mixes of hits, fills and collisions move the state through every ordering, every class mix and every mix of valid and invalid ways. Directed sequences fix the victim order for uniform-class fills and show that a hit keeps a poor-locality line first in line for eviction.

// File: rtl/lc_repl_pkg.sv
package lc_repl_pkg;

    typedef enum logic [1:0] {
        LC_POOR = 2'b00,
        LC_BAL  = 2'b01,
        LC_GOOD = 2'b10,
        LC_GOOD2 = 2'b11
    } lc_class_e;

    // eviction priority: lower value is evicted earlier
    function automatic logic [1:0] evict_prio(input logic [1:0] cls);
        logic [1:0] p;
        case (cls)
            2'b00:   p = 2'd0;
            2'b01:   p = 2'd1;
            default: p = 2'd2;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lc_repl_slot.sv
// Next-state logic of one way: rank shift, valid and class update.
module lc_repl_slot #(
    parameter int unsigned RW = 4
) (
    input  logic [RW-1:0] rank_i,
    input  logic          valid_i,
    input  logic [1:0]    cls_i,
    input  logic          move_i,
    input  logic          is_tgt_i,
    input  logic          fill_i,
    input  logic [1:0]    fill_cls_i,
    input  logic [RW-1:0] from_i,
    input  logic [RW-1:0] to_i,
    output logic [RW-1:0] rank_o,
    output logic          valid_o,
    output logic [1:0]    cls_o
);

    always_comb begin
        rank_o  = rank_i;
        valid_o = valid_i;
        cls_o   = cls_i;
        if (move_i) begin
            if (is_tgt_i) begin
                rank_o = to_i;
                if (fill_i) begin
                    valid_o = 1'b1;
                    cls_o   = fill_cls_i;
                end
            end else if (to_i > from_i) begin
                if (rank_i > from_i && rank_i <= to_i) rank_o = rank_i - 1'b1;
            end else if (to_i < from_i) begin
                if (rank_i >= to_i && rank_i < from_i) rank_o = rank_i + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lc_repl_victim.sv
// Chooses the way with the smallest key {valid, priority, rank}.
module lc_repl_victim
    import lc_repl_pkg::*;
#(
    parameter int unsigned WAYS = 16,
    localparam int unsigned RW = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]         valid_i,
    input  logic [WAYS-1:0][1:0]    cls_i,
    input  logic [WAYS-1:0][RW-1:0] rank_i,
    output logic [RW-1:0]           victim_o
);

    localparam int unsigned KW = RW + 3;

    logic [KW-1:0] best_key;
    logic [KW-1:0] key;

    always_comb begin
        best_key = '1;
        victim_o = '0;
        key      = '0;
        for (int w = 0; w < WAYS; w++) begin
            key = {valid_i[w], evict_prio(cls_i[w]), rank_i[w]};
            if (key < best_key) begin
                best_key = key;
                victim_o = RW'(w);
            end
        end
    end

endmodule

// File: rtl/lc_repl_set.sv
// Replacement state of one cache set with class-dependent insertion depth.
// WAYS must be a power of two, at least 2.
module lc_repl_set
    import lc_repl_pkg::*;
#(
    parameter int unsigned WAYS = 16,
    localparam int unsigned RW = $clog2(WAYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    input  logic          fill_i,
    input  logic [RW-1:0] way_i,
    input  logic [1:0]    cls_i,
    output logic [RW-1:0] victim_o
);

    localparam logic [RW-1:0] POS_TOP = RW'(WAYS - 1);
    localparam logic [RW-1:0] POS_MID = RW'(WAYS / 2);
    localparam logic [RW-1:0] POS_BOT = '0;

    typedef struct packed {
        logic [WAYS-1:0]         valid;
        logic [WAYS-1:0][1:0]    cls;
        logic [WAYS-1:0][RW-1:0] rank;
    } set_state_t;

    set_state_t state_q, state_d;

    logic [RW-1:0] from_pos, to_pos;
    logic          move;
    logic [WAYS-1:0][RW-1:0] rank_n;
    logic [WAYS-1:0]         valid_n;
    logic [WAYS-1:0][1:0]    cls_n;

    // insertion depth per class; a fill overrides a concurrent hit
    always_comb begin
        move     = hit_i | fill_i;
        from_pos = state_q.rank[way_i];
        if (fill_i) begin
            case (evict_prio(cls_i))
                2'd0:    to_pos = POS_BOT;
                2'd1:    to_pos = POS_MID;
                default: to_pos = POS_TOP;
            endcase
        end else begin
            to_pos = POS_TOP;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_slot
        lc_repl_slot #(.RW(RW)) u_slot (
            .rank_i     (state_q.rank[w]),
            .valid_i    (state_q.valid[w]),
            .cls_i      (state_q.cls[w]),
            .move_i     (move),
            .is_tgt_i   (way_i == RW'(w)),
            .fill_i     (fill_i),
            .fill_cls_i (cls_i),
            .from_i     (from_pos),
            .to_i       (to_pos),
            .rank_o     (rank_n[w]),
            .valid_o    (valid_n[w]),
            .cls_o      (cls_n[w])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.rank  = rank_n;
        state_d.valid = valid_n;
        state_d.cls   = cls_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.valid <= '0;
            state_q.cls   <= '0;
            for (int w = 0; w < WAYS; w++) state_q.rank[w] <= RW'(w);
        end else begin
            state_q <= state_d;
        end
    end

    lc_repl_victim #(.WAYS(WAYS)) u_victim (
        .valid_i  (state_q.valid),
        .cls_i    (state_q.cls),
        .rank_i   (state_q.rank),
        .victim_o (victim_o)
    );

endmodule

// File: rtl/lc_repl_set_chk.sv
module lc_repl_set_chk
    import lc_repl_pkg::*;
#(
    parameter int unsigned WAYS = 16,
    localparam int unsigned RW = $clog2(WAYS)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    hit_i,
    input logic                    fill_i,
    input logic [RW-1:0]           way_i,
    input logic [1:0]              cls_i,
    input logic [RW-1:0]           victim_o,
    input logic [WAYS-1:0]         valid_q,
    input logic [WAYS-1:0][1:0]    cls_q,
    input logic [WAYS-1:0][RW-1:0] rank_q
);

    logic [WAYS-1:0] seen;
    logic            lower_cls;

    always_comb begin
        seen      = '0;
        lower_cls = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            seen[rank_q[w]] = 1'b1;
            if (evict_prio(cls_q[w]) < evict_prio(cls_q[victim_o])) lower_cls = 1'b1;
        end
    end

    p_rank_perm_r4: assert property (@(posedge clk) disable iff (!rst_n) &seen);

    p_victim_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid_q) |-> !valid_q[victim_o]);

    p_victim_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_q) |-> !lower_cls);

    p_hit_mru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !fill_i) |=> rank_q[$past(way_i)] == RW'(WAYS - 1));

    p_hit_cls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !fill_i) |=> cls_q[$past(way_i)] == $past(cls_q[way_i]));

    p_fill_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && cls_i[1]) |=> rank_q[$past(way_i)] == RW'(WAYS - 1) && valid_q[$past(way_i)]);

    p_fill_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && cls_i == 2'b01) |=> rank_q[$past(way_i)] == RW'(WAYS / 2));

    p_fill_bot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && cls_i == 2'b00) |=> rank_q[$past(way_i)] == '0);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i && !fill_i) |=> $stable(rank_q) && $stable(valid_q) && $stable(cls_q));

endmodule

bind lc_repl_set lc_repl_set_chk #(.WAYS(WAYS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit_i),
    .fill_i   (fill_i),
    .way_i    (way_i),
    .cls_i    (cls_i),
    .victim_o (victim_o),
    .valid_q  (state_q.valid),
    .cls_q    (state_q.cls),
    .rank_q   (state_q.rank)
);

// File: tb/lc_repl_set_test.sv
module lc_repl_set_test;

    localparam int W  = 4;
    localparam int RW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hit = 1'b0;
    logic          fill = 1'b0;
    logic [RW-1:0] way = '0;
    logic [1:0]    cls = '0;
    logic [RW-1:0] victim;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_rank [W];
    bit m_valid [W];
    int m_cls [W];

    always #10 clk = ~clk;

    lc_repl_set #(.WAYS(W)) uut (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .fill_i(fill),
        .way_i(way), .cls_i(cls), .victim_o(victim)
    );

    function automatic int prio(int c);
        return (c == 0) ? 0 : (c == 1) ? 1 : 2;
    endfunction

    function automatic int exp_victim();
        int best = 0;
        int bk = 1 << 30;
        for (int w = 0; w < W; w++) begin
            int k = (int'(m_valid[w]) << 8) | (prio(m_cls[w]) << 4) | m_rank[w];
            if (k < bk) begin bk = k; best = w; end
        end
        return best;
    endfunction

    task automatic model_reset();
        for (int w = 0; w < W; w++) begin
            m_rank[w] = w; m_valid[w] = 0; m_cls[w] = 0;
        end
    endtask

    task automatic model_move(int w, int p);
        int r = m_rank[w];
        for (int k = 0; k < W; k++) begin
            if (k != w) begin
                if (p > r && m_rank[k] > r && m_rank[k] <= p) m_rank[k]--;
                else if (p < r && m_rank[k] >= p && m_rank[k] < r) m_rank[k]++;
            end
        end
        m_rank[w] = p;
    endtask

    task automatic check(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: victim actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(bit h, bit f, int w, int c, string tag);
        @(negedge clk);
        hit = h; fill = f; way = RW'(w); cls = 2'(c);
        @(posedge clk);
        #2;
        hit = 0; fill = 0;
        if (f) begin
            model_move(w, prio(c) == 0 ? 0 : prio(c) == 1 ? W / 2 : W - 1);
            m_valid[w] = 1; m_cls[w] = c;
        end else if (h) begin
            model_move(w, W - 1);
        end
        check(int'(victim), exp_victim(), tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1;
        model_reset();
        check(int'(victim), 0, "R1 reset victim");
    endtask

    initial begin
        logic [15:0] lfsr;
        model_reset();
        do_reset();

        // invalid ways first, lowest rank among them (R2)
        step(0, 1, 0, 2, "R2 R6 fill good");
        step(0, 1, 2, 1, "R2 R7 fill balanced");
        step(0, 0, 0, 0, "R11 idle hold");
        step(0, 1, 1, 0, "R2 R8 fill poor");
        step(0, 1, 3, 3, "R3 R10 fill code 3");

        // all poor: last filled sits at rank 0
        do_reset();
        for (int w = 0; w < W; w++) step(0, 1, w, 0, "R8 poor fill");
        check(int'(victim), 3, "R8 poor order");
        // all good: first filled is oldest
        do_reset();
        for (int w = 0; w < W; w++) step(0, 1, w, 2, "R6 good fill");
        check(int'(victim), 0, "R4 R6 good order");
        step(1, 0, 0, 0, "R4 R5 hit promotes");
        check(int'(victim), 1, "R5 hit moves oldest");

        // hit keeps poor class: still evicted first
        do_reset();
        step(0, 1, 0, 0, "R8 fill poor");
        for (int w = 1; w < W; w++) step(0, 1, w, 2, "R6 fill good");
        step(1, 0, 0, 1, "R5 hit keeps class");
        check(int'(victim), 0, "R3 R5 poor stays victim");

        // hit and fill together
        step(1, 1, 2, 0, "R9 R10 fill wins");
        check(int'(victim), 2, "R10 collided fill is poor");

        // pseudo-random sweep
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            int op;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op = int'(lfsr[1:0]);
            if (n % 997 == 996) do_reset();
            step(op != 2, op >= 2, int'(lfsr[5:4]), int'(lfsr[9:8]), "R2 R3 R4 R9 sweep");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule